// File: doc/BRIEF.md
# Prescaled 64-bit Cycle Counter

This block keeps a 64-bit count of clock cycles for a performance-monitoring unit. A small control word selects how it counts. One bit moves the overflow point from the low 32 bits to the full 64 bits. Another bit makes the counter step only once per 64 enabled clocks. A third bit freezes the counter while event counting for the lower counter group is prohibited. A fourth bit enables an exported per-increment event. Writing the control word with its command bit set zeroes the counter.

The counter advances only when the global enable and its own enable are both high. A sticky overflow flag records a wrap at the selected width and stays set until a dedicated flag-clear input is pulsed. Software-style writes can load any 64-bit value into the counter. The export output pulses for each increment, but only while export is enabled and counting is not prohibited.

Top module: `cycle_tally`

## Requirements
- R1: The counter changes only on a clock edge where `glb_en` and `own_en` are both 1. With either one at 0 and no write pending, `cnt_o` holds its value.
- R2: With control bit 1 (divide) at 0, the counter adds 1 on every enabled clock. With the divide bit at 1 and bit 2 at 0, it adds 1 once per 64 enabled clocks, counted from the last prescaler clear.
- R3: With control bit 2 (long overflow) at 1, the divide bit is ignored and the counter adds 1 on every enabled clock.
- R4: With the long bit at 0, `ovf_o` is set by an increment that takes bits 31:0 from all ones to zero. With the long bit at 1, only an increment from all 64 bits set sets it.
- R5: A control write with bit 0 (clear command) at 1 makes `cnt_o` zero on the next cycle whatever the long bit holds. It leaves `ovf_o` unchanged, and bit 0 of `ctl_rdata` always reads 0.
- R6: With control bit 3 (stop when prohibited) at 1, the counter does not advance while `prohibit_i` is 1. With bit 3 at 0, `prohibit_i` has no effect on counting.
- R7: `exp_valid_o` is 1 in the cycle after an increment only if control bit 4 (export) was 1 and `prohibit_i` was 0. The export bit has no effect on `ovf_o`.
- R8: `ovf_o` is sticky and is cleared only by `ovf_clr`. An overflow in the same cycle as `ovf_clr` leaves the flag set.
- R9: After reset, `cnt_o` is 0, `ovf_o` and `exp_valid_o` are 0, and `ctl_rdata` reads 5'b00100 (long bit 1, all other bits 0).
- R10: A write on `cnt_wr` loads `cnt_wdata` into the counter on the next cycle. A clear command in the same cycle takes priority.
- R11: The 6-bit prescaler is cleared by a clear command and by any control write that changes the divide bit. A write that keeps the divide bit unchanged leaves the prescaler alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low warm reset |
| glb_en | input | 1 | Global counter enable |
| own_en | input | 1 | This counter's own enable |
| prohibit_i | input | 1 | Counting for the lower counter group is prohibited |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 5 | Control word: bit0 clear command, bit1 divide, bit2 long overflow, bit3 stop when prohibited, bit4 export |
| ctl_rdata | output | 5 | Control word readback, bit0 always 0 |
| cnt_wr | input | 1 | Counter load strobe |
| cnt_wdata | input | CNT_W | Counter load value |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| cnt_o | output | CNT_W | Counter value |
| ovf_o | output | 1 | Sticky overflow flag |
| exp_valid_o | output | 1 | Exported increment event |

## Verification
The divide mode is swept over run lengths on both sides of each multiple of 64, so a prescaler that is off by one or that never wraps shows up as a wrong quotient. Loads just below the 32-bit and the 64-bit wrap points, tried in both overflow modes, separate a low-half wrap from a full wrap. The four enable combinations and the two settings of the stop bit under prohibition show which gate stops the count. Control rewrites that keep or flip the divide bit part way through a prescale period show whether the prescaler is cleared only when it should be.

// File: rtl/cycle_tally_pkg.sv
package cycle_tally_pkg;
   localparam int CTL_W  = 5;
   localparam int F_CLR  = 0;
   localparam int F_DIV  = 1;
   localparam int F_LONG = 2;
   localparam int F_STOP = 3;
   localparam int F_EXP  = 4;

   // stored control state, most significant field first (matches bits 4..1)
   typedef struct packed {
      logic exp_en;
      logic stop_on_prohib;
      logic long_ovf;
      logic div_sel;
   } ctl_t;

   localparam ctl_t CTL_RESET = '{exp_en: 1'b0, stop_on_prohib: 1'b0,
                                  long_ovf: 1'b1, div_sel: 1'b0};
endpackage

// File: rtl/cycle_tally_ctl.sv
module cycle_tally_ctl
   import cycle_tally_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [CTL_W-1:0] wdata,
   output ctl_t             ctl_q,
   output logic             clr_cmd,
   output logic             pre_clr,
   output logic [CTL_W-1:0] rdata
);
   ctl_t ctl_d;

   always_comb begin
      ctl_d = ctl_q;
      if (wr) begin
         ctl_d.exp_en         = wdata[F_EXP];
         ctl_d.stop_on_prohib = wdata[F_STOP];
         ctl_d.long_ovf       = wdata[F_LONG];
         ctl_d.div_sel        = wdata[F_DIV];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctl_q <= CTL_RESET;
      else        ctl_q <= ctl_d;
   end

   assign clr_cmd = wr & wdata[F_CLR];
   assign pre_clr = clr_cmd | (wr & (wdata[F_DIV] != ctl_q.div_sel));
   // the command bit is write-only and reads back as zero
   assign rdata   = {ctl_q, 1'b0};
endmodule

// File: rtl/cycle_tally_pre.sv
module cycle_tally_pre #(
   parameter int PRE_W = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic div_eff,
   input  logic sync_clr,
   output logic tick
);
   generate
      if (PRE_W == 0) begin : g_no_pre
         logic unused_pre;
         assign unused_pre = &{1'b0, clk, rst_n, div_eff, sync_clr};
         assign tick = run;
      end else begin : g_pre
         localparam logic [PRE_W-1:0] PRE_MAX = {PRE_W{1'b1}};
         localparam logic [PRE_W-1:0] PRE_ONE = {{(PRE_W-1){1'b0}}, 1'b1};
         logic [PRE_W-1:0] pre_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)               pre_q <= '0;
            else if (sync_clr)        pre_q <= '0;
            else if (run && div_eff)  pre_q <= pre_q + PRE_ONE;
         end

         assign tick = run & (!div_eff | (pre_q == PRE_MAX));
      end
   endgenerate
endmodule

// File: rtl/cycle_tally_cnt.sv
module cycle_tally_cnt #(
   parameter int CNT_W = 64,
   parameter int LOW_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             tick,
   input  logic             long_ovf,
   input  logic             ovf_clr,
   output logic [CNT_W-1:0] cnt_q,
   output logic             ovf_q,
   output logic             adv
);
   localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic full_wrap;
   logic low_wrap;
   logic wrap_hit;

   assign full_wrap = &cnt_q;

   generate
      if (LOW_W >= CNT_W) begin : g_same_width
         assign low_wrap = full_wrap;
      end else begin : g_split_width
         assign low_wrap = &cnt_q[LOW_W-1:0];
      end
   endgenerate

   assign adv      = tick & ~clr & ~load;
   assign wrap_hit = long_ovf ? full_wrap : low_wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (clr)  cnt_q <= '0;
      else if (load) cnt_q <= load_val;
      else if (adv)  cnt_q <= cnt_q + CNT_ONE;
   end

   // a new overflow wins over a simultaneous flag clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                ovf_q <= 1'b0;
      else if (adv && wrap_hit)  ovf_q <= 1'b1;
      else if (ovf_clr)          ovf_q <= 1'b0;
   end
endmodule

// File: rtl/cycle_tally.sv
module cycle_tally
   import cycle_tally_pkg::*;
#(
   parameter int CNT_W = 64,
   parameter int LOW_W = 32,
   parameter int PRE_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             glb_en,
   input  logic             own_en,
   input  logic             prohibit_i,
   input  logic             ctl_wr,
   input  logic [CTL_W-1:0] ctl_wdata,
   output logic [CTL_W-1:0] ctl_rdata,
   input  logic             cnt_wr,
   input  logic [CNT_W-1:0] cnt_wdata,
   input  logic             ovf_clr,
   output logic [CNT_W-1:0] cnt_o,
   output logic             ovf_o,
   output logic             exp_valid_o
);
   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("cycle_tally: CNT_W must be at least 2");
      end
      if (LOW_W < 1 || LOW_W > CNT_W) begin : g_bad_low
         $error("cycle_tally: LOW_W must lie in 1..CNT_W");
      end
      if (PRE_W < 0 || PRE_W > 16) begin : g_bad_pre
         $error("cycle_tally: PRE_W must lie in 0..16");
      end
   endgenerate

   ctl_t ctl_q;
   logic clr_cmd;
   logic pre_clr;
   logic run;
   logic div_eff;
   logic tick;
   logic adv;
   logic exp_q;

   cycle_tally_ctl u_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (ctl_wr),
      .wdata   (ctl_wdata),
      .ctl_q   (ctl_q),
      .clr_cmd (clr_cmd),
      .pre_clr (pre_clr),
      .rdata   (ctl_rdata)
   );

   assign run     = glb_en & own_en & ~(ctl_q.stop_on_prohib & prohibit_i);
   assign div_eff = ctl_q.div_sel & ~ctl_q.long_ovf;

   cycle_tally_pre #(.PRE_W(PRE_W)) u_pre (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .div_eff  (div_eff),
      .sync_clr (pre_clr),
      .tick     (tick)
   );

   cycle_tally_cnt #(.CNT_W(CNT_W), .LOW_W(LOW_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr_cmd),
      .load     (cnt_wr),
      .load_val (cnt_wdata),
      .tick     (tick),
      .long_ovf (ctl_q.long_ovf),
      .ovf_clr  (ovf_clr),
      .cnt_q    (cnt_o),
      .ovf_q    (ovf_o),
      .adv      (adv)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) exp_q <= 1'b0;
      else        exp_q <= adv & ctl_q.exp_en & ~prohibit_i;
   end

   assign exp_valid_o = exp_q;
endmodule

// File: rtl/cycle_tally_chk.sv
module cycle_tally_chk
   import cycle_tally_pkg::*;
#(
   parameter int CNT_W = 64
) (
   input logic             clk,
   input logic             rst_n,
   input logic             glb_en,
   input logic             own_en,
   input logic             prohibit_i,
   input logic             ctl_wr,
   input logic [CTL_W-1:0] ctl_wdata,
   input logic [CTL_W-1:0] ctl_rdata,
   input logic             cnt_wr,
   input logic [CNT_W-1:0] cnt_wdata,
   input logic             ovf_clr,
   input logic [CNT_W-1:0] cnt_o,
   input logic             ovf_o,
   input logic             exp_valid_o
);
   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic clr_w;
   logic no_wr;
   assign clr_w = ctl_wr & ctl_wdata[F_CLR];
   assign no_wr = ~cnt_wr & ~clr_w;

   // R1
   a_r1_hold_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      (no_wr && !(glb_en && own_en)) |=> (cnt_o == $past(cnt_o)));

   // R2
   a_r2_step_one: assert property (@(posedge clk) disable iff (!rst_n)
      no_wr |=> (cnt_o == $past(cnt_o) || cnt_o == $past(cnt_o) + ONE));

   // R5
   a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
      clr_w |=> (cnt_o == '0));

   // R5
   a_r5_clear_keeps_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_w && ovf_o && !ovf_clr) |=> ovf_o);

   // R5
   a_r5_cmd_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_rdata[F_CLR]);

   // R6
   a_r6_stop_prohib: assert property (@(posedge clk) disable iff (!rst_n)
      (no_wr && ctl_rdata[F_STOP] && prohibit_i) |=> (cnt_o == $past(cnt_o)));

   // R7
   a_r7_export_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_rdata[F_EXP] || prohibit_i) |=> !exp_valid_o);

   // R8
   a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_o && !ovf_clr) |=> ovf_o);

   // R10
   a_r10_load: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_wr && !clr_w) |=> (cnt_o == $past(cnt_wdata)));
endmodule

bind cycle_tally cycle_tally_chk #(.CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .glb_en      (glb_en),
   .own_en      (own_en),
   .prohibit_i  (prohibit_i),
   .ctl_wr      (ctl_wr),
   .ctl_wdata   (ctl_wdata),
   .ctl_rdata   (ctl_rdata),
   .cnt_wr      (cnt_wr),
   .cnt_wdata   (cnt_wdata),
   .ovf_clr     (ovf_clr),
   .cnt_o       (cnt_o),
   .ovf_o       (ovf_o),
   .exp_valid_o (exp_valid_o)
);

// File: tb/cycle_tally_tb_top.sv
module cycle_tally_tb_top;
   localparam int CNT_W = 64;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             glb_en = 1'b0;
   logic             own_en = 1'b1;
   logic             prohibit_i = 1'b0;
   logic             ctl_wr = 1'b0;
   logic [4:0]       ctl_wdata = '0;
   logic [4:0]       ctl_rdata;
   logic             cnt_wr = 1'b0;
   logic [CNT_W-1:0] cnt_wdata = '0;
   logic             ovf_clr = 1'b0;
   logic [CNT_W-1:0] cnt_o;
   logic             ovf_o;
   logic             exp_valid_o;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   cycle_tally dut_i (
      .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .own_en(own_en),
      .prohibit_i(prohibit_i), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
      .ctl_rdata(ctl_rdata), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
      .ovf_clr(ovf_clr), .cnt_o(cnt_o), .ovf_o(ovf_o),
      .exp_valid_o(exp_valid_o)
   );

   // control word: bit0 clear, bit1 divide, bit2 long, bit3 stop, bit4 export
   function automatic logic [4:0] cw(bit clr, bit dv, bit lg, bit st, bit ex);
      return {ex, st, lg, dv, clr};
   endfunction

   task automatic check(string tag, logic [CNT_W-1:0] act, logic [CNT_W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wr_ctl(logic [4:0] v);
      @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
      @(negedge clk); ctl_wr = 1'b0; ctl_wdata = '0;
   endtask

   task automatic load(logic [CNT_W-1:0] v);
      @(negedge clk); cnt_wr = 1'b1; cnt_wdata = v;
      @(negedge clk); cnt_wr = 1'b0;
   endtask

   task automatic run(int n);
      @(negedge clk); glb_en = 1'b1;
      repeat (n) @(negedge clk);
      glb_en = 1'b0;
   endtask

   task automatic pulse_ovf_clr();
      @(negedge clk); ovf_clr = 1'b1;
      @(negedge clk); ovf_clr = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      int ns[9] = '{0, 1, 63, 64, 65, 127, 128, 129, 200};
      logic [CNT_W-1:0] base;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R9 reset state
      check("R9 cnt", cnt_o, 0);
      check("R9 ovf", {63'd0, ovf_o}, 0);
      check("R9 exp", {63'd0, exp_valid_o}, 0);
      check("R9 ctl", {59'd0, ctl_rdata}, 64'h4);

      // R1 enable combinations, long=1 so every enabled clock counts
      base = cnt_o;
      for (int k = 0; k < 4; k++) begin
         own_en = k[0];
         @(negedge clk); glb_en = k[1];
         repeat (10) @(negedge clk);
         glb_en = 1'b0;
         if (k == 3) base = base + 10;
         check("R1 enable pair", cnt_o, base);
      end
      own_en = 1'b1;

      // R2 divide off: one per clock
      wr_ctl(cw(1, 0, 0, 0, 0));
      for (int k = 1; k < 40; k += 13) begin
         base = cnt_o;
         run(k);
         check("R2 undivided", cnt_o, base + k);
      end

      // R2 divide on, sweep around multiples of 64
      foreach (ns[i]) begin
         wr_ctl(cw(1, 1, 0, 0, 0));
         run(ns[i]);
         check("R2 divided", cnt_o, ns[i] / 64);
      end

      // R11 same divide value keeps prescaler; change clears it
      wr_ctl(cw(1, 1, 0, 0, 0));
      run(40);
      wr_ctl(cw(0, 1, 0, 0, 0));
      run(24);
      check("R11 prescaler kept", cnt_o, 1);
      wr_ctl(cw(1, 1, 0, 0, 0));
      run(40);
      wr_ctl(cw(0, 0, 0, 0, 0));
      wr_ctl(cw(0, 1, 0, 0, 0));
      run(24);
      check("R11 prescaler cleared", cnt_o, 0);

      // R3 long overrides divide
      wr_ctl(cw(1, 1, 1, 0, 0));
      run(50);
      check("R3 divide ignored", cnt_o, 50);

      // R4 short overflow
      wr_ctl(cw(0, 0, 0, 0, 0));
      load(64'h0000_0000_FFFF_FFFE);
      check("R10 load", cnt_o, 64'h0000_0000_FFFF_FFFE);
      run(1);
      check("R4 short no flag yet", {63'd0, ovf_o}, 0);
      run(1);
      check("R4 short flag", {63'd0, ovf_o}, 1);
      check("R4 short value", cnt_o, 64'h0000_0001_0000_0000);

      // R8 sticky and cleared only by ovf_clr
      run(5);
      check("R8 sticky", {63'd0, ovf_o}, 1);
      pulse_ovf_clr();
      check("R8 cleared", {63'd0, ovf_o}, 0);

      // R4 long: low wrap does not flag, full wrap does
      wr_ctl(cw(0, 0, 1, 0, 0));
      load(64'h0000_0000_FFFF_FFFF);
      run(1);
      check("R4 long low wrap", {63'd0, ovf_o}, 0);
      load(64'hFFFF_FFFF_FFFF_FFFF);
      run(1);
      check("R4 long full wrap", {63'd0, ovf_o}, 1);
      check("R4 long value", cnt_o, 0);

      // R5 clear keeps flag, zeroes all bits, command reads 0
      load(64'h1234_5678_9ABC_DEF0);
      wr_ctl(cw(1, 0, 1, 0, 0));
      check("R5 zeroed", cnt_o, 0);
      check("R5 flag kept", {63'd0, ovf_o}, 1);
      check("R5 readback", {59'd0, ctl_rdata}, 64'h4);
      wr_ctl(cw(1, 0, 0, 0, 0));
      check("R5 zeroed short mode", cnt_o, 0);

      // R8 overflow wins over simultaneous clear
      load(64'h0000_0000_FFFF_FFFF);
      @(negedge clk); glb_en = 1'b1; ovf_clr = 1'b1;
      @(negedge clk); glb_en = 1'b0; ovf_clr = 1'b0;
      check("R8 set wins", {63'd0, ovf_o}, 1);
      pulse_ovf_clr();

      // R6 stop when prohibited
      wr_ctl(cw(1, 0, 1, 1, 0));
      prohibit_i = 1'b1;
      run(10);
      check("R6 stopped", cnt_o, 0);
      wr_ctl(cw(0, 0, 1, 0, 0));
      run(10);
      check("R6 prohibit ignored", cnt_o, 10);
      prohibit_i = 1'b0;

      // R7 export gating
      wr_ctl(cw(1, 0, 1, 0, 1));
      run(3);
      check("R7 export on", {63'd0, exp_valid_o}, 1);
      @(negedge clk);
      check("R7 export idle", {63'd0, exp_valid_o}, 0);
      prohibit_i = 1'b1;
      run(3);
      check("R7 export prohibited", {63'd0, exp_valid_o}, 0);
      prohibit_i = 1'b0;
      wr_ctl(cw(0, 0, 0, 0, 0));
      run(3);
      check("R7 export off", {63'd0, exp_valid_o}, 0);
      load(64'h0000_0000_FFFF_FFFF);
      run(1);
      check("R7 flag without export", {63'd0, ovf_o}, 1);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule